// File: doc/BRIEF.md
# GCD Accelerator Bus Peripheral

A memory-mapped slave peripheral that works out the greatest common divisor of two unsigned words by repeated subtraction. Software stores the two operands in two word registers and then writes the value 1 to a control word. The same control word is read back to collect the answer. While the datapath is still working, that read returns a busy pattern.

The datapath does one compare-and-subtract step per clock. The larger working value loses the smaller one. When they are equal, the second working value is the one reduced. The loop ends when the second value is zero, and the first value is then the result. Latency depends on the data, so software polls the control word until the busy pattern goes away.

Every access completes in the cycle it is presented, with no wait states. Ready is always high and the response is always OKAY. Read data is combinational from the address, so a read's data is valid in the same cycle as the address.

Top module: `gcd_accel`

## Requirements
- R1: A write to word address 0 stores operand A and a write to word address 1 stores operand B. This holds only while no computation is running. Reading either address returns the stored value.
- R2: Writing exactly 1 to word address 2 while idle starts a computation. From the next cycle until it finishes, reads of address 2 return 0xFFFFFFFF.
- R3: Each busy cycle that does not finish performs one step. If the first working value is strictly greater than the second, the first becomes first minus second. Otherwise the second becomes second minus first. The finished result equals the greatest common divisor, and equal operands give that operand.
- R4: A computation whose operand B is zero spends exactly one cycle busy and returns operand A.
- R5: A computation whose operand A is zero spends exactly one cycle busy and returns 0.
- R6: Writes to addresses 0 and 1 made while busy leave the stored operands unchanged.
- R7: A write to address 2 of any value other than 1 starts nothing, and so does a write of 1 made while busy. In both cases address 2 keeps returning its previous content.
- R8: A synchronous active-high reset returns the block to the idle state, aborting any running computation. After reset, reads of addresses 0, 1 and 2 all return 0.
- R9: Reads of any word address above 2 return 0, and writes to them change no readable register.
- R10: bus_ready is 1 and bus_resp is 0 (OKAY) on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address within the window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the access cycle |
| bus_ready | output | 1 | Access complete, always 1 |
| bus_resp | output | 1 | Response, 0 = OKAY |

## Verification
The bench targets the degenerate operands. For B zero, a design that tests for zero only after a step would take extra cycles or return garbage. For A zero, the bare subtract loop never ends and polling would hang. For equal operands, a design using a greater-or-equal compare would clear the first value and return 0. It also writes operands and a second start mid-run, which would corrupt the answer in a design without a busy guard. A reset in mid-run catches a datapath that keeps stepping after reset. Out-of-range addresses and non-1 control writes are read back to show that no register moved.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int OFF_OPA  = 0;
  localparam int OFF_OPB  = 1;
  localparam int OFF_CTRL = 2;
  localparam int GO_VALUE = 1;
  localparam bit RESP_OKAY = 1'b0;
endpackage

// File: rtl/gcd_step.sv
module gcd_step #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur_a,
  input  logic [DATA_W-1:0] cur_b,
  output logic [DATA_W-1:0] nxt_a,
  output logic [DATA_W-1:0] nxt_b,
  output logic              finish
);
  logic a_gt_b;

  always_comb begin
    a_gt_b = cur_a > cur_b;
    finish = (cur_b == '0) || (cur_a == '0);
    nxt_a  = cur_a;
    nxt_b  = cur_b;
    if (a_gt_b) nxt_a = cur_a - cur_b;
    else        nxt_b = cur_b - cur_a;
  end
endmodule

// File: rtl/gcd_core.sv
module gcd_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] load_a,
  input  logic [DATA_W-1:0] load_b,
  output logic              busy,
  output logic [DATA_W-1:0] work_a,
  output logic [DATA_W-1:0] work_b,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] step_a, step_b;
  logic              step_done;

  gcd_step #(.DATA_W(DATA_W)) u_step (
    .cur_a (work_a),
    .cur_b (work_b),
    .nxt_a (step_a),
    .nxt_b (step_b),
    .finish(step_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      work_a <= '0;
      work_b <= '0;
      result <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      work_a <= load_a;
      work_b <= load_b;
    end else if (busy) begin
      if (step_done) begin
        result <= work_a;
        busy   <= 1'b0;
      end else begin
        work_a <= step_a;
        work_b <= step_b;
      end
    end
  end
endmodule

// File: rtl/gcd_regs.sv
module gcd_regs
  import gcd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic              start
);
  localparam logic [ADDR_W-1:0] A_OPA  = ADDR_W'(OFF_OPA);
  localparam logic [ADDR_W-1:0] A_OPB  = ADDR_W'(OFF_OPB);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [DATA_W-1:0] GO     = DATA_W'(GO_VALUE);

  logic wr_idle;

  always_comb begin
    wr_idle = bus_sel && bus_write && !busy;
    start   = wr_idle && (bus_addr == A_CTRL) && (bus_wdata == GO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a <= '0;
      op_b <= '0;
    end else if (wr_idle) begin
      if (bus_addr == A_OPA) op_a <= bus_wdata;
      if (bus_addr == A_OPB) op_b <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_write) begin
      unique case (bus_addr)
        A_OPA:   bus_rdata = op_a;
        A_OPB:   bus_rdata = op_b;
        A_CTRL:  bus_rdata = busy ? '1 : result;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gcd_accel.sv
module gcd_accel
  import gcd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_resp
);
  logic              busy, start;
  logic [DATA_W-1:0] op_a, op_b, work_a, work_b, result;

  assign bus_ready = 1'b1;
  assign bus_resp  = RESP_OKAY;

  gcd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .busy     (busy),
    .result   (result),
    .bus_rdata(bus_rdata),
    .op_a     (op_a),
    .op_b     (op_b),
    .start    (start)
  );

  gcd_core #(.DATA_W(DATA_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load_a(op_a),
    .load_b(op_b),
    .busy  (busy),
    .work_a(work_a),
    .work_b(work_b),
    .result(result)
  );
endmodule

// File: rtl/gcd_accel_chk.sv
module gcd_accel_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              busy,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] work_a,
  input logic [DATA_W-1:0] work_b,
  input logic [DATA_W-1:0] result
);
  logic [DATA_W:0] wsum;
  assign wsum = {1'b0, work_a} + {1'b0, work_b};

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_write && bus_addr == ADDR_W'(2) && bus_wdata == DATA_W'(1) && !busy) |=> busy);

  assert_busy_read_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_sel && !bus_write && bus_addr == ADDR_W'(2)) |-> (bus_rdata == '1));

  assert_shrink_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && work_a != '0 && work_b != '0) |=> (busy && wsum < $past(wsum)));

  assert_zero_end_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && (work_b == '0 || work_a == '0)) |=> (!busy && result == $past(work_a)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(op_a) && $stable(op_b)));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!busy && result == '0 && op_a == '0 && op_b == '0));

  assert_oor_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_write && bus_addr > ADDR_W'(2)) |-> (bus_rdata == '0));
endmodule

bind gcd_accel gcd_accel_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .busy     (busy),
  .op_a     (op_a),
  .op_b     (op_b),
  .work_a   (work_a),
  .work_b   (work_b),
  .result   (result)
);

// File: tb/tb_gcd_accel.sv
module tb_gcd_accel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_req = 1'b1;
  logic        bus_sel = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, bus_resp;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [31:0] last_rd;

  // behavioural reference state
  logic [31:0] m_a = 0, m_b = 0, m_wa = 0, m_wb = 0, m_res = 0;
  bit m_busy = 0;

  always #5 clk = ~clk;

  gcd_accel dut (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_resp(bus_resp));

  function automatic logic [31:0] ref_gcd(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] t;
    if (a == 0) return 0;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    case (a)
      0: return m_a;
      1: return m_b;
      2: return m_busy ? 32'hFFFF_FFFF : m_res;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit s, input bit w, input int a, input logic [31:0] d);
    if (rst) begin
      m_a = 0; m_b = 0; m_wa = 0; m_wb = 0; m_res = 0; m_busy = 0;
    end else if (s && w && !m_busy && a == 2 && d == 1) begin
      m_wa = m_a; m_wb = m_b; m_busy = 1;
    end else if (m_busy) begin
      if (m_wb == 0 || m_wa == 0) begin m_res = m_wa; m_busy = 0; end
      else if (m_wa > m_wb) m_wa = m_wa - m_wb;
      else m_wb = m_wb - m_wa;
    end else if (s && w) begin
      if (a == 0) m_a = d;
      if (a == 1) m_b = d;
    end
  endtask

  task automatic cyc(input bit s, input bit w, input int a, input logic [31:0] d, input string tag);
    @(negedge clk);
    rst = rst_req; bus_sel = s; bus_write = w; bus_addr = a[3:0]; bus_wdata = d;
    #1;
    chk({31'd0, bus_ready}, 32'd1, {"R10 ready ", tag});
    chk({31'd0, bus_resp}, 32'd0, {"R10 resp ", tag});
    if (s && !w) begin
      last_rd = bus_rdata;
      chk(bus_rdata, model_read(a), tag);
    end
    @(posedge clk);
    model_step(s, w, a, d);
  endtask

  task automatic poll(input string tag, output int busy_cnt);
    busy_cnt = 0;
    cyc(1, 0, 2, 0, tag);
    while (last_rd == 32'hFFFF_FFFF && busy_cnt < 5000) begin
      busy_cnt++;
      cyc(1, 0, 2, 0, tag);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y, input string tag);
    int n;
    cyc(1, 1, 0, x, tag);
    cyc(1, 1, 1, y, tag);
    cyc(1, 0, 0, 0, {"R1 ", tag});
    cyc(1, 0, 1, 0, {"R1 ", tag});
    cyc(1, 1, 2, 1, tag);
    poll({"R2 poll ", tag}, n);
    chk(last_rd, ref_gcd(x, y), {"R3 euclid ", tag});
    if (y == 0) chk(n, 1, {"R4 busy cycles ", tag});
    if (x == 0) chk(n, 1, {"R5 busy cycles ", tag});
  endtask

  initial begin
    int n;
    cyc(0, 0, 0, 0, "reset");
    cyc(0, 0, 0, 0, "reset");
    rst_req = 0;
    cyc(1, 0, 0, 0, "R8 reset opA");
    cyc(1, 0, 1, 0, "R8 reset opB");
    cyc(1, 0, 2, 0, "R8 reset ctrl");
    run(20, 10, "R3 20,10");
    run(3, 10, "R3 3,10");
    run(39, 10, "R3 39,10");
    run(42, 10, "R3 42,10");
    run(40, 10, "R3 40,10");
    run(12, 18, "R3 12,18");
    run(7, 7, "R3 equal");
    run(9, 0, "R4 b zero");
    run(0, 5, "R5 a zero");
    run(0, 0, "R5 both zero");
    // R7: non-1 control write while idle
    cyc(1, 1, 2, 2, "R7 write 2");
    cyc(1, 0, 2, 0, "R7 no start");
    chk(last_rd, 0, "R7 result kept");
    cyc(1, 1, 2, 32'h8000_0001, "R7 write big");
    cyc(1, 0, 2, 0, "R7 no start big");
    // R6 / R7 during a long run
    cyc(1, 1, 0, 300, "R6 setup");
    cyc(1, 1, 1, 7, "R6 setup");
    cyc(1, 1, 2, 1, "R6 start");
    cyc(1, 1, 0, 5, "R6 write A busy");
    cyc(1, 1, 1, 9, "R6 write B busy");
    cyc(1, 1, 2, 1, "R7 restart busy");
    cyc(1, 0, 0, 0, "R6 opA held");
    chk(last_rd, 300, "R6 opA value");
    cyc(1, 0, 1, 0, "R6 opB held");
    chk(last_rd, 7, "R6 opB value");
    poll("R6 poll", n);
    chk(last_rd, 1, "R6 result");
    // R9 out-of-range
    cyc(1, 1, 5, 32'h1234, "R9 write oor");
    cyc(1, 1, 15, 32'hFFFF, "R9 write oor");
    cyc(1, 0, 5, 0, "R9 read 5");
    cyc(1, 0, 15, 0, "R9 read 15");
    cyc(1, 0, 0, 0, "R9 opA unchanged");
    cyc(1, 0, 1, 0, "R9 opB unchanged");
    cyc(1, 0, 2, 0, "R9 ctrl unchanged");
    // long run, then R8 reset mid-computation
    run(1000, 1, "R3 1000,1");
    cyc(1, 1, 0, 900, "R8 setup");
    cyc(1, 1, 2, 1, "R8 start");
    repeat (4) cyc(1, 0, 2, 0, "R8 busy");
    rst_req = 1;
    cyc(0, 0, 0, 0, "R8 reset");
    rst_req = 0;
    cyc(1, 0, 0, 0, "R8 opA clear");
    chk(last_rd, 0, "R8 opA zero");
    cyc(1, 0, 1, 0, "R8 opB clear");
    cyc(1, 0, 2, 0, "R8 ctrl clear");
    chk(last_rd, 0, "R8 ctrl zero");
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule